// File: doc/BRIEF.md
# Single-Channel DMA Engine

This block moves a programmed number of data words between one peripheral data port and system memory, with no processor work per word. Software first writes a start memory address, a word count, a peripheral select value, a transfer direction and a transfer mode into a small write-only register port, then arms the engine. From then on the peripheral paces the transfer with a request line. The engine asks the processor for the system bus, waits for the grant, and moves one word in every cycle in which it owns the bus and the peripheral is ready. The peripheral gets an acknowledge strobe in each moving cycle.

Each moved word advances the memory address by one and reduces the remaining count by one. When the last word has moved, the engine gives the bus back and raises an interrupt. The interrupt stays high until software clears it. Three pacing modes set how the bus is held. Burst keeps the bus for the whole block. Cycle-steal gives the bus back after every word. Idle-only keeps requesting but moves words only in cycles that the processor marks as bus-idle.

Top module: `dma_engine`

## Requirements
- R1: While reset is held, `bus_req`, `dev_ack`, `mem_we`, `dev_we` and `irq` are 0 and `mem_addr` is 0.
- R2: An armed engine keeps `bus_req` low while `dev_req` is low. `bus_req` goes high on the clock edge after `dev_req` is first seen high.
- R3: A word moves (`dev_ack` high) only in a cycle where `bus_req` and `bus_grant` are both high. In any other cycle `mem_addr` is 0 and `mem_we`, `dev_we` and `dev_ack` are low.
- R4: With direction bit 0 (peripheral to memory), a moving cycle has `mem_we`=1, `dev_we`=0 and `mem_wdata`=`dev_rdata`. With direction bit 1 (memory to peripheral), it has `dev_we`=1, `mem_we`=0, `dev_wdata`=`mem_rdata`, and `dev_sel` equal to the programmed select value.
- R5: An armed block of N words produces exactly N `dev_ack` cycles. The k-th word (k from 0) uses `mem_addr` = start + k, wrapping modulo 2^ADDR_W.
- R6: In burst mode (mode field 0), once `bus_req` has risen it stays high in every cycle up to and including the final word, even in cycles where `dev_req` is low.
- R7: In cycle-steal mode (mode field 1), `bus_req` is low in the cycle after every moved word.
- R8: In idle-only mode (mode field 2), `dev_ack` is high only in cycles where `cpu_idle` is high.
- R9: In the cycle after the final word, `bus_req` is 0 and `irq` is 1.
- R10: A control write with bit 4 set clears `irq` on the next edge. If that write lands in the same cycle as the final word of a block, `irq` stays 1.
- R11: While a block is in progress, writes to the address (select 0), count (select 1), peripheral (select 2) registers and to the direction, mode and arm bits of the control register (select 3) have no effect.
- R12: Arming (control select 3, bit 0) with a count of 0 raises `irq` on the next edge and never raises `bus_req`.
- R13: Mode field value 3 (control bits 3:2) behaves as burst mode. Control bit 1 is the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 peripheral, 3 control |
| cfg_wdata | input | CFG_W | Register write data; control bits are 0 arm, 1 direction, 3:2 mode, 4 irq clear |
| dev_req | input | 1 | Peripheral ready for a word |
| dev_ack | output | 1 | High for the cycle in which the peripheral's word moves |
| dev_sel | output | DEV_W | Programmed peripheral select value |
| dev_rdata | input | DATA_W | Word from the peripheral |
| dev_wdata | output | DATA_W | Word to the peripheral |
| dev_we | output | 1 | Peripheral write strobe |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | Bus granted by the processor |
| cpu_idle | input | 1 | Processor marks the bus as idle this cycle |
| mem_addr | output | ADDR_W | Word address to memory, 0 when the bus is not owned |
| mem_rdata | input | DATA_W | Word read from memory |
| mem_wdata | output | DATA_W | Word written to memory |
| mem_we | output | 1 | Memory write strobe |
| irq | output | 1 | Block-complete interrupt |

## Verification
Two events can meet in one cycle: software's interrupt-clear write and the move of a block's final word, which sets the interrupt. The bench arms a one-word block while an older interrupt is still pending. It withholds the grant until the request is up, then drives the grant and the clear write in the same cycle. The expected outcome is an acknowledge in that cycle and `irq` still high in the next cycle. A later clear write on its own must then bring `irq` low.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam logic [1:0] SEL_MADDR = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_DEV   = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

  localparam int unsigned CTL_GO      = 0;
  localparam int unsigned CTL_DIR     = 1;
  localparam int unsigned CTL_MODE_LO = 2;
  localparam int unsigned CTL_CLR     = 4;

  typedef enum logic [1:0] {
    MODE_BURST     = 2'd0,
    MODE_STEAL     = 2'd1,
    MODE_SNOOP     = 2'd2,
    MODE_BURST_ALT = 2'd3
  } xfer_mode_e;

endpackage

// File: rtl/dma_cfg.sv
module dma_cfg
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DEV_W  = 4,
  parameter int unsigned CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  start_cnt,
  output logic [DEV_W-1:0]  dev_sel,
  output logic              dir,
  output xfer_mode_e        mode,
  output logic              go,
  output logic              clr,
  output logic              zero_cnt
);

  logic hit_ctrl, wr_open;
  logic en_addr, en_cnt, en_dev, en_ctl;

  always_comb begin
    wr_open  = cfg_we && !busy;
    hit_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
    en_addr  = wr_open && (cfg_sel == SEL_MADDR);
    en_cnt   = wr_open && (cfg_sel == SEL_COUNT);
    en_dev   = wr_open && (cfg_sel == SEL_DEV);
    en_ctl   = wr_open && (cfg_sel == SEL_CTRL);
    go       = en_ctl && cfg_wdata[CTL_GO];
    clr      = hit_ctrl && cfg_wdata[CTL_CLR];
    zero_cnt = (start_cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      start_cnt  <= '0;
      dev_sel    <= '0;
      dir        <= 1'b0;
      mode       <= MODE_BURST;
    end else begin
      if (en_addr) start_addr <= cfg_wdata[ADDR_W-1:0];
      if (en_cnt)  start_cnt  <= cfg_wdata[CNT_W-1:0];
      if (en_dev)  dev_sel    <= cfg_wdata[DEV_W-1:0];
      if (en_ctl) begin
        dir  <= cfg_wdata[CTL_DIR];
        mode <= xfer_mode_e'(cfg_wdata[CTL_MODE_LO +: 2]);
      end
    end
  end

  // R11: data registers hold while a block runs
  assert_busy_regs_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && cfg_sel != SEL_CTRL) |=>
      ($stable(start_addr) && $stable(start_cnt) && $stable(dev_sel)));

  // R11: control fields hold while a block runs
  assert_busy_ctl_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hit_ctrl) |=> ($stable(mode) && $stable(dir)));

endmodule

// File: rtl/dma_walker.sv
module dma_walker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last
);

  logic [CNT_W-1:0]  remaining;
  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              en;

  always_comb begin
    en     = load || step;
    addr_d = cur_addr;
    cnt_d  = remaining;
    if (load) begin
      addr_d = ld_addr;
      cnt_d  = ld_cnt;
    end else if (step) begin
      addr_d = cur_addr + ADDR_W'(1);
      cnt_d  = remaining - CNT_W'(1);
    end
    last = (remaining == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
    end else if (en) begin
      cur_addr  <= addr_d;
      remaining <= cnt_d;
    end
  end

  // R5: one word forward per move
  assert_addr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

  // R5: one fewer word left per move
  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (remaining == $past(remaining) - CNT_W'(1)));

endmodule

// File: rtl/dma_bus_ctl.sv
module dma_bus_ctl
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       zero_cnt,
  input  xfer_mode_e mode,
  input  logic       drq,
  input  logic       bus_grant,
  input  logic       cpu_idle,
  input  logic       last,
  input  logic       clr,
  output logic       step,
  output logic       bus_req,
  output logic       busy,
  output logic       irq
);

  logic idle_ok, finish;
  logic busy_d, req_d, irq_d;

  always_comb begin
    idle_ok = (mode != MODE_SNOOP) || cpu_idle;
    step    = busy && bus_req && bus_grant && drq && idle_ok;
    finish  = step && last;

    busy_d = busy;
    if (go)          busy_d = !zero_cnt;
    else if (finish) busy_d = 1'b0;

    req_d = bus_req;
    if (!busy || finish)                      req_d = 1'b0;
    else if (!bus_req)                        req_d = drq;
    else if (step && (mode == MODE_STEAL))    req_d = 1'b0;

    irq_d = irq;
    if (clr)                           irq_d = 1'b0;
    if (finish || (go && zero_cnt))    irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bus_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      busy    <= busy_d;
      bus_req <= req_d;
      irq     <= irq_d;
    end
  end

  assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && busy && !(step && last) &&
     (mode == MODE_BURST || mode == MODE_BURST_ALT)) |=> bus_req);

  assert_steal_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == MODE_STEAL) |=> !bus_req);

  assert_final_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (irq && !bus_req && !busy));

  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(step && last) && !(go && zero_cnt)) |=> !irq);

  assert_empty_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (go && zero_cnt) |=> (irq && !bus_req && !busy));

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DEV_W  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic [DEV_W-1:0]  dev_sel,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_we,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              cpu_idle,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              irq
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] start_addr, cur_addr;
  logic [CNT_W-1:0]  start_cnt;
  logic              dir, go, clr, zero_cnt, busy, step, last, owned;
  xfer_mode_e        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dma_cfg #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .start_addr(start_addr),
    .start_cnt(start_cnt), .dev_sel(dev_sel), .dir(dir), .mode(mode),
    .go(go), .clr(clr), .zero_cnt(zero_cnt)
  );

  dma_walker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_walker (
    .clk(clk), .rst_n(rst_sync_n), .load(go), .ld_addr(start_addr),
    .ld_cnt(start_cnt), .step(step), .cur_addr(cur_addr), .last(last)
  );

  dma_bus_ctl u_bus (
    .clk(clk), .rst_n(rst_sync_n), .go(go), .zero_cnt(zero_cnt), .mode(mode),
    .drq(dev_req), .bus_grant(bus_grant), .cpu_idle(cpu_idle), .last(last),
    .clr(clr), .step(step), .bus_req(bus_req), .busy(busy), .irq(irq)
  );

  always_comb begin
    owned     = bus_req && bus_grant;
    dev_ack   = step;
    mem_addr  = owned ? cur_addr : '0;
    mem_we    = step && !dir;
    dev_we    = step && dir;
    mem_wdata = mem_we ? dev_rdata : '0;
    dev_wdata = dev_we ? mem_rdata : '0;
  end

  assert_quiet_unowned_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !owned |-> (mem_addr == '0 && !mem_we && !dev_we && !dev_ack));

  assert_snoop_idle_only_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dev_ack |-> (mode != MODE_SNOOP || cpu_idle));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({mem_we, dev_we}) == (dev_ack ? 1 : 0));

endmodule

// File: tb/test_dma_engine.sv
module test_dma_engine;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic        dev_req;
  logic        dev_ack;
  logic [3:0]  dev_sel;
  logic [15:0] dev_rdata;
  logic [15:0] dev_wdata;
  logic        dev_we;
  logic        bus_req;
  logic        bus_grant;
  logic        cpu_idle;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        irq;
  logic [15:0] k16;

  int total = 0;
  int bad   = 0;

  // {mode, dir, start, count, dev, drq pattern, idle pattern}
  localparam logic [46:0] VECS [6] = '{
    {2'd0, 1'b0, 16'h0100, 8'd5, 4'h3, 8'hFF,       8'hFF},
    {2'd0, 1'b1, 16'hFFFE, 8'd4, 4'hA, 8'b11011011, 8'hFF},
    {2'd1, 1'b0, 16'h2000, 8'd4, 4'h5, 8'hFF,       8'hFF},
    {2'd1, 1'b1, 16'h0040, 8'd3, 4'h1, 8'b10101110, 8'hFF},
    {2'd2, 1'b0, 16'h3000, 8'd5, 4'h7, 8'hFF,       8'b10010110},
    {2'd3, 1'b1, 16'h0500, 8'd3, 4'hF, 8'b11101111, 8'hFF}
  };

  assign mem_rdata = mem_addr ^ 16'h5A5A;
  assign dev_rdata = 16'hC000 + k16;

  dma_engine i_dma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_sel(dev_sel), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
    .dev_we(dev_we), .bus_req(bus_req), .bus_grant(bus_grant),
    .cpu_idle(cpu_idle), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input int idx);
    logic [46:0] v;
    logic [1:0]  md;
    logic        dr;
    logic [15:0] st;
    logic [7:0]  n, dp, ip;
    logic [3:0]  dv;
    int seen;
    bit fin, done9, req_up, prev_ack, e_addr, e_data, e_grant, e_mode;
    string tag;
    v  = VECS[idx];
    md = v[46:45]; dr = v[44]; st = v[43:28]; n = v[27:20];
    dv = v[19:16]; dp = v[15:8]; ip = v[7:0];
    seen = 0; fin = 0; done9 = 0; req_up = 0; prev_ack = 0;
    e_addr = 0; e_data = 0; e_grant = 0; e_mode = 0;
    k16 = 16'd0;
    wr(2'd0, st);
    wr(2'd1, {8'd0, n});
    wr(2'd2, {12'd0, dv});
    wr(2'd3, {11'd0, 1'b0, md, dr, 1'b1});
    for (int cyc = 0; cyc < 400 && !done9; cyc++) begin
      dev_req   = dp[cyc % 8];
      cpu_idle  = ip[cyc % 8];
      bus_grant = bus_req;
      #1;
      if (fin) begin
        chk(!bus_req && irq, "R9 bus released and irq raised after final word",
            {30'd0, bus_req, irq}, 32'h1);
        done9 = 1;
      end else begin
        if (bus_req) req_up = 1;
        if ((md == 2'd0 || md == 2'd3) && req_up && !bus_req) e_mode = 1;
        if (md == 2'd1 && prev_ack && bus_req) e_mode = 1;
        if (md == 2'd2 && dev_ack && !cpu_idle) e_mode = 1;
        prev_ack = dev_ack;
        if (dev_ack) begin
          if (!(bus_req && bus_grant)) e_grant = 1;
          if (mem_addr != st + 16'(seen)) e_addr = 1;
          if (!dr) begin
            if (!mem_we || dev_we || mem_wdata != 16'hC000 + 16'(seen)) e_data = 1;
          end else begin
            if (!dev_we || mem_we || dev_sel != dv ||
                dev_wdata != ((st + 16'(seen)) ^ 16'h5A5A)) e_data = 1;
          end
          seen++;
          if (seen == int'(n)) fin = 1;
        end
      end
      @(negedge clk);
      k16 = 16'(seen);
    end
    tag = (md == 2'd1) ? "R7 steal releases bus after each word" :
          (md == 2'd2) ? "R8 words only in idle cycles" :
          (md == 2'd3) ? "R13 mode 3 holds bus like burst" :
                         "R6 burst holds bus";
    chk(seen == int'(n), "R5 word count", 32'(seen), 32'(n));
    chk(!e_addr, "R5 address sequence", {31'd0, e_addr}, 32'h0);
    chk(!e_data, "R4 data path and strobes", {31'd0, e_data}, 32'h0);
    chk(!e_grant, "R3 acknowledge only while granted", {31'd0, e_grant}, 32'h0);
    chk(!e_mode, tag, {31'd0, e_mode}, 32'h0);
    chk(done9, "R9 completion reached", {31'd0, done9}, 32'h1);
    dev_req = 1'b0; bus_grant = 1'b0; cpu_idle = 1'b0;
    wr(2'd3, 16'h0010);
    #1;
    chk(!irq, "R10 clear write drops irq", {31'd0, irq}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seen;
    logic [15:0] first;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 16'd0;
    dev_req = 1'b0; bus_grant = 1'b0; cpu_idle = 1'b0; k16 = 16'd0;
    repeat (3) @(negedge clk);
    #1;
    chk(!bus_req && !dev_ack && !mem_we && !dev_we && !irq && mem_addr == 16'd0,
        "R1 reset outputs quiet",
        {11'd0, bus_req, dev_ack, mem_we, dev_we, irq, mem_addr}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 6; i++) run_vec(i);

    // R2 / R3 / R11: paced request, withheld grant, writes while busy
    wr(2'd0, 16'h0A00);
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd4);
    dev_req = 1'b0; bus_grant = 1'b0;
    wr(2'd3, 16'h0001);
    repeat (3) @(negedge clk);
    #1;
    chk(!bus_req, "R2 no request while device idle", {31'd0, bus_req}, 32'h0);
    @(negedge clk);
    dev_req = 1'b1;
    #1;
    chk(!bus_req, "R2 request waits for clock edge", {31'd0, bus_req}, 32'h0);
    @(negedge clk);
    #1;
    chk(bus_req, "R2 request after device request", {31'd0, bus_req}, 32'h1);
    chk(!dev_ack && !mem_we && mem_addr == 16'd0, "R3 no bus drive before grant",
        {15'd0, dev_ack, mem_addr}, 32'h0);
    wr(2'd1, 16'd50);
    wr(2'd0, 16'h7777);
    wr(2'd3, 16'h0005);
    seen = 0; first = 16'hFFFF;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      bus_grant = bus_req;
      k16 = 16'(seen);
      #1;
      if (irq) break;
      if (dev_ack) begin
        if (seen == 0) first = mem_addr;
        seen++;
      end
    end
    chk(seen == 2, "R11 count write ignored while busy", 32'(seen), 32'd2);
    chk(first == 16'h0A00, "R11 address write ignored while busy", {16'd0, first}, 32'h0A00);
    bus_grant = 1'b0;

    // R10: clear write meets final word; irq still pending from above
    wr(2'd0, 16'h0900);
    wr(2'd1, 16'd1);
    wr(2'd3, 16'h0001);
    @(negedge clk);
    #1;
    chk(bus_req && irq, "R10 request up with older irq pending", {30'd0, bus_req, irq}, 32'h3);
    @(negedge clk);
    bus_grant = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 16'h0010;
    #1;
    chk(dev_ack, "R10 final word in the clear cycle", {31'd0, dev_ack}, 32'h1);
    @(negedge clk);
    cfg_we = 1'b0; bus_grant = 1'b0;
    #1;
    chk(irq, "R10 completion wins over clear", {31'd0, irq}, 32'h1);
    chk(!bus_req, "R9 request dropped after single word", {31'd0, bus_req}, 32'h0);
    wr(2'd3, 16'h0010);
    #1;
    chk(!irq, "R10 later clear drops irq", {31'd0, irq}, 32'h0);

    // R12: empty block
    dev_req = 1'b0;
    wr(2'd1, 16'd0);
    wr(2'd3, 16'h0001);
    #1;
    chk(irq && !bus_req, "R12 zero count completes at once", {30'd0, irq, bus_req}, 32'h2);
    dev_req = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!bus_req, "R12 no request for empty block", {31'd0, bus_req}, 32'h0);
    dev_req = 1'b0;
    wr(2'd3, 16'h0010);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule